// File: doc/BRIEF.md
# Double-Pumped Warp Multiply-Add Sequencer

This block runs 32-element warp instructions on an array of only 16 physical multiply-add lanes. Each lane computes one multiply-add per ALU clock. The ALU clock runs at twice the issue clock, so every warp instruction is cut into two halves. The lower half runs on the first ALU edge of the issue cycle and the upper half runs on the second. The issuer never sees the split: it hands over one instruction per issue cycle and gets back one complete 32-element result vector, tagged with the warp that sent it.

Each instruction carries 32 operand triples (a, b, c) and a 6-bit warp identifier. Up to 48 warps can be resident. The arithmetic is unsigned integer multiply-add. Choosing which warp to issue is done upstream and is not part of this block.

The two clocks share aligned rising edges, and every second ALU rising edge coincides with an issue rising edge. The synchronous reset comes from a register in the issue domain, so it changes just after an issue edge. The half-select toggle lives in the ALU domain. Reset aligns it so that the first ALU edge inside an issue cycle always handles the lower half.

Top module: `warp_dual_pump`

## Requirements
- R1: Each result element i equals (a_i * b_i + c_i) modulo 2^20, with a_i and b_i 8-bit unsigned values and c_i 20-bit unsigned. Element i occupies bits [i*8 +: 8] of each operand bus, bits [i*20 +: 20] of in_c, and bits [i*20 +: 20] of out_res.
- R2: Elements 0 to 15 are computed on the first ALU edge of an issue cycle and elements 16 to 31 on the second. Each output element depends only on the operands at its own index, so different data in the two halves never mix.
- R3: An instruction is accepted on the issue edge where in_valid is high. Its result and warp id become valid together on the next issue edge and stay stable for exactly one issue cycle.
- R4: A new instruction can be accepted on every issue edge with no bubble. Results leave in acceptance order, one per issue cycle.
- R5: The warp id (6 bits, legal values 0 to 47) comes back unchanged with its result. Values of 48 and above are illegal inputs.
- R6: If in_valid is low at an issue edge, out_valid is low during the issue cycle that follows the next issue edge.
- R7: While rst is high at a clock edge, out_valid goes low. An instruction accepted just before reset is asserted produces no valid result.
- R8: The multiply-add wraps at 20 bits. For example, a = b = 255 and c = 0xFFFFF gives 0x0FE00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_issue | input | 1 | Issue clock |
| clk_alu | input | 1 | ALU clock at twice the issue rate, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset, issue-domain timed |
| in_valid | input | 1 | Instruction present this issue cycle |
| in_wid | input | 6 | Warp identifier of the instruction |
| in_a | input | 256 | 32 multiplicands, 8 bits each |
| in_b | input | 256 | 32 multipliers, 8 bits each |
| in_c | input | 640 | 32 addends, 20 bits each |
| out_valid | output | 1 | Result vector valid |
| out_wid | output | 6 | Warp identifier of the result |
| out_res | output | 640 | 32 results, 20 bits each |

## Verification
The bench drives lower and upper halves with deliberately different data. A design that swapped the halves, or fed one half into both, would return upper-half values in the low elements. Back-to-back runs with changing warp ids catch a result register that holds a stale id, or one that drops every second instruction. Idle slots and a reset right after acceptance expose a valid flag that sticks or one that survives reset. All-ones operands check that the multiply-add wraps at 20 bits instead of saturating or widening.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    // Resident warp limit and the id width derived from it
    localparam int MAX_WARPS    = 48;
    localparam int WID_W        = $clog2(MAX_WARPS);

    // ALU clock to issue clock ratio: number of passes per instruction
    localparam int PUMP         = 2;

    // Default datapath shape
    localparam int DEF_WARP_LEN = 32;
    localparam int DEF_OP_W     = 8;
    localparam int DEF_ACC_W    = 20;

    // Which half of the warp the lanes work on
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Control tag that travels beside the operand data
    typedef struct packed {
        logic             valid;
        logic [WID_W-1:0] wid;
    } warp_tag_t;

    function automatic half_e next_half(input half_e h);
        return (h == HALF_LO) ? HALF_HI : HALF_LO;
    endfunction

endpackage

// File: rtl/wdp_issue_stage.sv
module wdp_issue_stage
    import wdp_pkg::*;
#(
    parameter int WARP_LEN = DEF_WARP_LEN,
    parameter int OP_W     = DEF_OP_W,
    parameter int ACC_W    = DEF_ACC_W
) (
    input  logic                      clk_issue,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WID_W-1:0]          in_wid,
    input  logic [WARP_LEN*OP_W-1:0]  in_a,
    input  logic [WARP_LEN*OP_W-1:0]  in_b,
    input  logic [WARP_LEN*ACC_W-1:0] in_c,
    output warp_tag_t                 tag_q,
    output logic [WARP_LEN*OP_W-1:0]  a_q,
    output logic [WARP_LEN*OP_W-1:0]  b_q,
    output logic [WARP_LEN*ACC_W-1:0] c_q
);

    // The control tag is reset; operand storage only loads on a valid slot
    always_ff @(posedge clk_issue) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= in_valid;
            if (in_valid) begin
                tag_q.wid <= in_wid;
            end
        end
    end

    always_ff @(posedge clk_issue) begin
        if (in_valid) begin
            a_q <= in_a;
            b_q <= in_b;
            c_q <= in_c;
        end
    end

    AST_WID_LEGAL: assert property (@(posedge clk_issue) disable iff (rst)
        in_valid |-> (in_wid < WID_W'(MAX_WARPS))); // R5

    AST_ACCEPT_EVERY_CYCLE: assert property (@(posedge clk_issue) disable iff (rst)
        in_valid |=> tag_q.valid); // R4

    AST_WID_CAPTURE: assert property (@(posedge clk_issue) disable iff (rst)
        in_valid |=> (tag_q.wid == $past(in_wid))); // R5

endmodule

// File: rtl/wdp_phase_gen.sv
module wdp_phase_gen
    import wdp_pkg::*;
(
    input  logic  clk_alu,
    input  logic  rst,
    output half_e phase
);

    // The reset is released just after an issue edge, so the first ALU edge
    // after release is the mid-cycle edge, and that edge handles the lower half.
    always_ff @(posedge clk_alu) begin
        if (rst) begin
            phase <= HALF_LO;
        end else begin
            phase <= next_half(phase);
        end
    end

endmodule

// File: rtl/wdp_lane_array.sv
module wdp_lane_array
    import wdp_pkg::*;
#(
    parameter int WARP_LEN = DEF_WARP_LEN,
    parameter int LANES    = DEF_WARP_LEN / PUMP,
    parameter int OP_W     = DEF_OP_W,
    parameter int ACC_W    = DEF_ACC_W
) (
    input  half_e                     phase,
    input  logic [WARP_LEN*OP_W-1:0]  a_q,
    input  logic [WARP_LEN*OP_W-1:0]  b_q,
    input  logic [WARP_LEN*ACC_W-1:0] c_q,
    output logic [LANES*ACC_W-1:0]    lane_res
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO_IDX = l;
        localparam int HI_IDX = l + LANES;

        logic [OP_W-1:0]  op_a;
        logic [OP_W-1:0]  op_b;
        logic [ACC_W-1:0] op_c;

        // Operand steering: one lane serves element l, then element l+LANES
        always_comb begin
            if (phase == HALF_HI) begin
                op_a = a_q[HI_IDX*OP_W  +: OP_W];
                op_b = b_q[HI_IDX*OP_W  +: OP_W];
                op_c = c_q[HI_IDX*ACC_W +: ACC_W];
            end else begin
                op_a = a_q[LO_IDX*OP_W  +: OP_W];
                op_b = b_q[LO_IDX*OP_W  +: OP_W];
                op_c = c_q[LO_IDX*ACC_W +: ACC_W];
            end
        end

        // Unsigned multiply-add, wrapping at the accumulator width
        assign lane_res[l*ACC_W +: ACC_W] = (ACC_W'(op_a) * ACC_W'(op_b)) + op_c;
    end

endmodule

// File: rtl/wdp_result_stage.sv
module wdp_result_stage
    import wdp_pkg::*;
#(
    parameter int WARP_LEN = DEF_WARP_LEN,
    parameter int LANES    = DEF_WARP_LEN / PUMP,
    parameter int ACC_W    = DEF_ACC_W
) (
    input  logic                      clk_alu,
    input  logic                      rst,
    input  half_e                     phase,
    input  logic [LANES*ACC_W-1:0]    lane_res,
    input  warp_tag_t                 tag_in,
    output warp_tag_t                 res_tag,
    output logic [WARP_LEN*ACC_W-1:0] res_q
);

    logic [LANES*ACC_W-1:0] lo_hold;

    // Mid-cycle edge: park the lower half.
    // Edge aligned with the issue clock: join the upper half and publish.
    always_ff @(posedge clk_alu) begin
        if (rst) begin
            lo_hold <= '0;
            res_tag <= '0;
            res_q   <= '0;
        end else if (phase == HALF_LO) begin
            lo_hold <= lane_res;
        end else begin
            res_q   <= {lane_res, lo_hold};
            res_tag <= tag_in;
        end
    end

    AST_LO_KEPT_IN_HI: assert property (@(posedge clk_alu) disable iff (rst)
        (phase == HALF_HI) |=> $stable(lo_hold)); // R2

    AST_RES_HOLDS_MID: assert property (@(posedge clk_alu) disable iff (rst)
        (phase == HALF_LO) |=> ($stable(res_tag) && $stable(res_q))); // R3

endmodule

// File: rtl/warp_dual_pump.sv
module warp_dual_pump
    import wdp_pkg::*;
#(
    parameter int WARP_LEN = DEF_WARP_LEN,
    parameter int OP_W     = DEF_OP_W,
    parameter int ACC_W    = DEF_ACC_W
) (
    input  logic                      clk_issue,
    input  logic                      clk_alu,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WID_W-1:0]          in_wid,
    input  logic [WARP_LEN*OP_W-1:0]  in_a,
    input  logic [WARP_LEN*OP_W-1:0]  in_b,
    input  logic [WARP_LEN*ACC_W-1:0] in_c,
    output logic                      out_valid,
    output logic [WID_W-1:0]          out_wid,
    output logic [WARP_LEN*ACC_W-1:0] out_res
);

    localparam int LANES = WARP_LEN / PUMP;

    warp_tag_t                 iss_tag;
    logic [WARP_LEN*OP_W-1:0]  iss_a;
    logic [WARP_LEN*OP_W-1:0]  iss_b;
    logic [WARP_LEN*ACC_W-1:0] iss_c;
    half_e                     phase;
    logic [LANES*ACC_W-1:0]    lane_res;
    warp_tag_t                 res_tag;

    wdp_issue_stage #(
        .WARP_LEN(WARP_LEN), .OP_W(OP_W), .ACC_W(ACC_W)
    ) u_issue (
        .clk_issue(clk_issue), .rst(rst),
        .in_valid(in_valid), .in_wid(in_wid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .tag_q(iss_tag), .a_q(iss_a), .b_q(iss_b), .c_q(iss_c)
    );

    wdp_phase_gen u_phase (
        .clk_alu(clk_alu), .rst(rst), .phase(phase)
    );

    wdp_lane_array #(
        .WARP_LEN(WARP_LEN), .LANES(LANES), .OP_W(OP_W), .ACC_W(ACC_W)
    ) u_lanes (
        .phase(phase), .a_q(iss_a), .b_q(iss_b), .c_q(iss_c),
        .lane_res(lane_res)
    );

    wdp_result_stage #(
        .WARP_LEN(WARP_LEN), .LANES(LANES), .ACC_W(ACC_W)
    ) u_result (
        .clk_alu(clk_alu), .rst(rst), .phase(phase),
        .lane_res(lane_res), .tag_in(iss_tag),
        .res_tag(res_tag), .res_q(out_res)
    );

    assign out_valid = res_tag.valid;
    assign out_wid   = res_tag.wid;

    // Issue-domain view across the two stages
    AST_OUT_FOLLOWS_ISSUE: assert property (@(posedge clk_issue) disable iff (rst)
        iss_tag.valid |=> out_valid); // R3

    AST_OUT_WID_MATCH: assert property (@(posedge clk_issue) disable iff (rst)
        iss_tag.valid |=> (out_wid == $past(iss_tag.wid))); // R5

    AST_IDLE_SLOT: assert property (@(posedge clk_issue) disable iff (rst)
        !iss_tag.valid |=> !out_valid); // R6

endmodule

// File: tb/sim_warp_dual_pump.sv
`timescale 1ns/1ps
module sim_warp_dual_pump;
    import wdp_pkg::*;

    localparam int WL = 32;
    localparam int OW = 8;
    localparam int AW = 20;

    logic               clk_issue = 1'b0;
    logic               clk_alu   = 1'b0;
    logic               rst       = 1'b1;
    logic               in_valid  = 1'b0;
    logic [WID_W-1:0]   in_wid    = '0;
    logic [WL*OW-1:0]   in_a      = '0;
    logic [WL*OW-1:0]   in_b      = '0;
    logic [WL*AW-1:0]   in_c      = '0;
    logic               out_valid;
    logic [WID_W-1:0]   out_wid;
    logic [WL*AW-1:0]   out_res;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Staged operands, set by the scenario before each slot
    logic [OW-1:0] st_a [WL];
    logic [OW-1:0] st_b [WL];
    logic [AW-1:0] st_c [WL];

    // Expectation history: index 0 = previous slot, 1 = two slots back
    logic             hv [2];
    logic [WID_W-1:0] hw [2];
    logic [WL*AW-1:0] hr [2];
    string            ht [2];

    warp_dual_pump u0 (
        .clk_issue(clk_issue), .clk_alu(clk_alu), .rst(rst),
        .in_valid(in_valid), .in_wid(in_wid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_wid(out_wid), .out_res(out_res)
    );

    // 100 MHz issue clock, ALU clock at twice the rate with aligned rising edges
    initial forever begin
        #2.5 clk_alu = 1'b1; clk_issue = 1'b1;
        #2.5 clk_alu = 1'b0;
        #2.5 clk_alu = 1'b1; clk_issue = 1'b0;
        #2.5 clk_alu = 1'b0;
    end

    task automatic clear_history(input string tag);
        for (int k = 0; k < 2; k++) begin
            hv[k] = 1'b0; hw[k] = '0; hr[k] = '0; ht[k] = tag;
        end
    endtask

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < WL; i++) begin
            st_a[i] = OW'(seed * 29 + i * 7 + 5);
            st_b[i] = OW'(seed * 13 + i * 3 + 1);
            st_c[i] = AW'(seed * 4099 + i * 977);
        end
    endtask

    task automatic check_out(input logic v, input logic [WID_W-1:0] w,
                             input logic [WL*AW-1:0] r, input string tag);
        checks++;
        if (out_valid !== v) begin
            errors++;
            $display("FAIL %s: out_valid got %b exp %b", tag, out_valid, v);
        end else if (v) begin
            if (out_wid !== w) begin
                errors++;
                $display("FAIL %s: out_wid got %0d exp %0d", tag, out_wid, w);
            end else if (out_res !== r) begin
                errors++;
                for (int i = 0; i < WL; i++) begin
                    if (out_res[i*AW +: AW] !== r[i*AW +: AW]) begin
                        $display("FAIL %s: element %0d got %h exp %h", tag, i,
                                 out_res[i*AW +: AW], r[i*AW +: AW]);
                        break;
                    end
                end
            end
        end
    endtask

    // One issue slot: drive after the edge, check the slot issued two edges back
    task automatic slot(input bit v, input logic [WID_W-1:0] w, input string tag);
        logic [WL*AW-1:0] exp_r;
        @(posedge clk_issue);
        #2;
        in_valid = v;
        in_wid   = w;
        for (int i = 0; i < WL; i++) begin
            in_a[i*OW +: OW] = st_a[i];
            in_b[i*OW +: OW] = st_b[i];
            in_c[i*AW +: AW] = st_c[i];
            exp_r[i*AW +: AW] = AW'(int'(st_a[i]) * int'(st_b[i]) + int'(st_c[i]));
        end
        #4;
        check_out(hv[1], hw[1], hr[1], ht[1]);
        hv[1] = hv[0]; hw[1] = hw[0]; hr[1] = hr[0]; ht[1] = ht[0];
        hv[0] = v;     hw[0] = w;     hr[0] = exp_r; ht[0] = tag;
    endtask

    task automatic drain(input string tag);
        slot(1'b0, '0, tag);
        slot(1'b0, '0, tag);
    endtask

    // R7: outputs idle after reset
    task automatic test_reset_state();
        clear_history("R7");
        fill_pattern(0);
        drain("R7");
    endtask

    // R1, R3: one instruction with idle slots around it
    task automatic test_single();
        fill_pattern(1);
        slot(1'b1, 6'd5, "R1");
        slot(1'b0, '0,   "R3");
        drain("R3");
    endtask

    // R4: a dense stream with no gaps
    task automatic test_back_to_back();
        for (int n = 0; n < 6; n++) begin
            fill_pattern(10 + n);
            slot(1'b1, WID_W'(n * 7), "R4");
        end
        drain("R4");
    endtask

    // R2: very different data in the two halves
    task automatic test_split_halves();
        for (int i = 0; i < WL; i++) begin
            if (i < WL/2) begin
                st_a[i] = 8'd1;   st_b[i] = OW'(i + 1); st_c[i] = AW'(i);
            end else begin
                st_a[i] = 8'd200; st_b[i] = 8'd250;    st_c[i] = AW'(i * 30000);
            end
        end
        slot(1'b1, 6'd12, "R2");
        for (int i = 0; i < WL; i++) begin
            st_a[i] = (i < WL/2) ? 8'd240 : 8'd3;
            st_b[i] = (i < WL/2) ? 8'd17  : 8'd2;
            st_c[i] = (i < WL/2) ? 20'h0   : 20'hABCDE;
        end
        slot(1'b1, 6'd13, "R2");
        drain("R2");
    endtask

    // R5: boundary warp ids back to back
    task automatic test_wid_range();
        fill_pattern(21); slot(1'b1, 6'd0,  "R5");
        fill_pattern(22); slot(1'b1, 6'd47, "R5");
        fill_pattern(23); slot(1'b1, 6'd46, "R5");
        fill_pattern(24); slot(1'b1, 6'd1,  "R5");
        drain("R5");
    endtask

    // R6: idle slots between instructions
    task automatic test_gaps();
        fill_pattern(31); slot(1'b1, 6'd9,  "R6");
        fill_pattern(32); slot(1'b0, 6'd9,  "R6");
        fill_pattern(33); slot(1'b1, 6'd10, "R6");
        fill_pattern(34); slot(1'b0, 6'd11, "R6");
        drain("R6");
    endtask

    // R8: all-ones operands wrap at 20 bits (0xFFFFF + 0xFE01 -> 0x0FE00)
    task automatic test_wrap();
        for (int i = 0; i < WL; i++) begin
            st_a[i] = 8'hFF; st_b[i] = 8'hFF; st_c[i] = 20'hFFFFF;
        end
        slot(1'b1, 6'd33, "R8");
        for (int i = 0; i < WL; i++) begin
            st_c[i] = (i % 2 == 0) ? 20'hF01FF : 20'h00000;
        end
        slot(1'b1, 6'd34, "R8");
        drain("R8");
    endtask

    // R7: reset right after acceptance kills the result
    task automatic test_reset_midflight();
        fill_pattern(41);
        slot(1'b1, 6'd20, "R7");
        @(posedge clk_issue);
        #2;
        rst      = 1'b1;
        in_valid = 1'b0;
        @(posedge clk_issue);
        #6;
        check_out(1'b0, '0, '0, "R7");
        @(posedge clk_issue);
        #2;
        rst = 1'b0;
        clear_history("R7");
        drain("R7");
        fill_pattern(42);
        slot(1'b1, 6'd21, "R7");
        drain("R7");
    endtask

    initial begin
        clear_history("R7");
        repeat (3) @(posedge clk_issue);
        #2;
        rst = 1'b0;
        test_reset_state();
        test_single();
        test_back_to_back();
        test_split_halves();
        test_wid_range();
        test_gaps();
        test_wrap();
        test_reset_midflight();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule